// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the active-lane mask of one wavefront on a SIMD core and resolves divergent branches and loops with a stack of saved masks. An issue stage hands it one decoded control operation per cycle: a push that stores the current mask together with a resume address, a narrowing operation that clears every lane whose per-lane condition is zero, or a return that ends the wavefront. All other instructions are presented as a neutral operation and leave the mask alone.

Exit from a divergent region or loop is implicit. When a narrowing operation would leave no lane active, the block pops the top entry on its own, restores the saved mask and asks the fetch unit to jump to the saved address. A loop is formed by pushing the exit label once before the loop body, narrowing on a per-lane comparison every iteration and jumping back; when the last lane drops out, fetch is sent to the exit label with the pre-loop mask. Stack overflow and underflow set sticky error flags. Lane count, stack depth (at least 2) and address width are parameters.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the stack is empty, the active mask has every lane set, no redirect is raised, and the overflow, underflow and done flags are low.
- R2: An accepted push (code 1) stores the current mask and the supplied resume address on the stack and leaves the active mask unchanged.
- R3: An accepted narrowing operation (code 2) whose result is nonzero replaces the active mask with the AND of the active mask and the per-lane condition vector, so a cleared lane stays cleared until its entry is popped.
- R4: An accepted narrowing operation whose AND result is zero, with a non-empty stack, pops the top entry; in the next cycle the active mask equals the saved mask, the redirect valid is high for that one cycle and the redirect address equals the saved address.
- R5: Nested entries are restored in last-in first-out order, each pop returning the mask and address of the most recent remaining push.
- R6: A push while the stack holds its full depth sets a sticky overflow flag and leaves the stack and mask unchanged.
- R7: A narrowing operation with a zero result on an empty stack sets a sticky underflow flag, raises no redirect and leaves the mask unchanged.
- R8: A neutral operation (code 0) changes neither the mask nor the stack.
- R9: A return (code 3) sets a sticky done flag; afterwards every operation is ignored.
- R10: When the operation valid input is low, the operation code and condition inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation presented this cycle |
| opCode | input | 2 | 0 neutral, 1 push, 2 narrow, 3 return |
| condNz | input | LANES | Per-lane nonzero flags of the condition register |
| pushPc | input | PCW | Resume address stored by a push |
| actMask | output | LANES | Current active-lane mask |
| redirValid | output | 1 | Fetch redirect request, one cycle |
| redirPc | output | PCW | Fetch redirect target |
| ovfErr | output | 1 | Sticky stack overflow flag |
| unfErr | output | 1 | Sticky stack underflow flag |
| waveDone | output | 1 | Sticky wavefront finished flag |

## Verification
A corrupted stack entry or depth count stays hidden until the matching pop, where it appears as a wrong restored mask or a wrong redirect address in the cycle after the narrowing operation that empties the lanes. A wrong mask register appears on the next clock at the mask port. The reference model therefore compares every output each cycle and the stimulus drives each pushed entry back out through a pop, including the entries below an overflowing push.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [1:0] {
    OP_OTHER  = 2'd0,
    OP_PUSH   = 2'd1,
    OP_NARROW = 2'd2,
    OP_RET    = 2'd3
  } opKind_t;

  typedef struct packed {
    logic push;
    logic narrow;
    logic pop;
  } stackStrb_t;

  typedef struct packed {
    logic full;
    logic empty;
    logic narrowZero;
  } stackStat_t;
endpackage

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
  import simt_mask_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opCode,
  input  stackStat_t stat,
  output stackStrb_t strb,
  output logic       ovfErr,
  output logic       unfErr,
  output logic       waveDone
);
  logic accept;
  logic isPush, isNarrow, isRet;
  logic ovfQ, unfQ, doneQ;

  assign accept   = opValid && !doneQ;
  assign isPush   = accept && (opCode == OP_PUSH);
  assign isNarrow = accept && (opCode == OP_NARROW);
  assign isRet    = accept && (opCode == OP_RET);

  always_comb begin
    strb.push   = isPush && !stat.full;
    strb.narrow = isNarrow && !stat.narrowZero;
    strb.pop    = isNarrow && stat.narrowZero && !stat.empty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfQ  <= 1'b0;
      unfQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      if (isPush && stat.full) ovfQ <= 1'b1;
      if (isNarrow && stat.narrowZero && stat.empty) unfQ <= 1'b1;
      if (isRet) doneQ <= 1'b1;
    end
  end

  assign ovfErr   = ovfQ;
  assign unfErr   = unfQ;
  assign waveDone = doneQ;
endmodule

// File: rtl/simt_mask_dp.sv
module simt_mask_dp
  import simt_mask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int PCW   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackStrb_t       strb,
  input  logic [LANES-1:0] condNz,
  input  logic [PCW-1:0]   pushPc,
  output stackStat_t       stat,
  output logic [LANES-1:0] actMask,
  output logic             redirValid,
  output logic [PCW-1:0]   redirPc
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int DW   = $clog2(DEPTH + 1);

  logic [LANES-1:0] maskStk [DEPTH];
  logic [PCW-1:0]   pcStk   [DEPTH];
  logic [DW-1:0]    depthQ;
  logic [LANES-1:0] maskQ;
  logic [LANES-1:0] narrowed;
  logic [IDXW-1:0]  topIdx, wrIdx;
  logic             redirQ;
  logic [PCW-1:0]   redirPcQ;

  assign narrowed = maskQ & condNz;
  assign wrIdx    = IDXW'(depthQ);
  assign topIdx   = IDXW'(depthQ - DW'(1));

  always_comb begin
    stat.full       = (depthQ == DW'(DEPTH));
    stat.empty      = (depthQ == '0);
    stat.narrowZero = (narrowed == '0);
  end

  always_ff @(posedge clk) begin
    if (strb.push) begin
      maskStk[wrIdx] <= maskQ;
      pcStk[wrIdx]   <= pushPc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthQ   <= '0;
      maskQ    <= '1;
      redirQ   <= 1'b0;
      redirPcQ <= '0;
    end else begin
      redirQ <= strb.pop;
      if (strb.push) begin
        depthQ <= depthQ + DW'(1);
      end else if (strb.pop) begin
        depthQ   <= depthQ - DW'(1);
        maskQ    <= maskStk[topIdx];
        redirPcQ <= pcStk[topIdx];
      end else if (strb.narrow) begin
        maskQ <= narrowed;
      end
    end
  end

  assign actMask    = maskQ;
  assign redirValid = redirQ;
  assign redirPc    = redirPcQ;
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int PCW   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [LANES-1:0] condNz,
  input  logic [PCW-1:0]   pushPc,
  output logic [LANES-1:0] actMask,
  output logic             redirValid,
  output logic [PCW-1:0]   redirPc,
  output logic             ovfErr,
  output logic             unfErr,
  output logic             waveDone
);
  stackStrb_t strb;
  stackStat_t stat;

  simt_mask_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .stat(stat), .strb(strb),
    .ovfErr(ovfErr), .unfErr(unfErr), .waveDone(waveDone)
  );

  simt_mask_dp #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .condNz(condNz), .pushPc(pushPc),
    .stat(stat), .actMask(actMask), .redirValid(redirValid), .redirPc(redirPc)
  );
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
  parameter int LANES = 8,
  parameter int PCW   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [1:0]       opCode,
  input logic [LANES-1:0] condNz,
  input logic [LANES-1:0] actMask,
  input logic             redirValid,
  input logic             ovfErr,
  input logic             unfErr,
  input logic             waveDone
);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);

  a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    unfErr |=> unfErr);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    waveDone |=> waveDone);

  a_r4_redir_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(redirValid) |-> $past(opValid && opCode == 2'd2 && !waveDone));

  a_r3_narrow_and: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'd2 && !waveDone && ((actMask & condNz) != '0))
      |=> (actMask == $past(actMask & condNz)) && !redirValid);

  a_r8_other_keeps_mask: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'd0) |=> $stable(actMask) && !redirValid);

  a_r10_idle_keeps_mask: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(actMask) && !redirValid);
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .PCW(PCW)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .condNz(condNz),
  .actMask(actMask), .redirValid(redirValid), .ovfErr(ovfErr),
  .unfErr(unfErr), .waveDone(waveDone)
);

// File: tb/test_simt_mask_stack.sv
module test_simt_mask_stack;
  localparam int LANES = 8;
  localparam int DEPTH = 4;
  localparam int PCW   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opCode = 2'd0;
  logic [LANES-1:0] condNz = '0;
  logic [PCW-1:0] pushPc = '0;
  logic [LANES-1:0] actMask;
  logic redirValid;
  logic [PCW-1:0] redirPc;
  logic ovfErr, unfErr, waveDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) i_simt_mask_stack (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .condNz(condNz),
    .pushPc(pushPc), .actMask(actMask), .redirValid(redirValid), .redirPc(redirPc),
    .ovfErr(ovfErr), .unfErr(unfErr), .waveDone(waveDone)
  );

  // behavioural reference
  logic [LANES-1:0] mMask;
  logic [LANES-1:0] mStkMask[$];
  logic [PCW-1:0]   mStkPc[$];
  logic mRedir, mOvf, mUnf, mDone;
  logic [PCW-1:0] mRedirPc;

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = '1; mStkMask.delete(); mStkPc.delete();
      mRedir = 0; mRedirPc = '0; mOvf = 0; mUnf = 0; mDone = 0;
    end else begin
      mRedir = 0;
      if (opValid && !mDone) begin
        case (opCode)
          2'd1: if (mStkMask.size() >= DEPTH) mOvf = 1;
                else begin mStkMask.push_back(mMask); mStkPc.push_back(pushPc); end
          2'd2: if ((mMask & condNz) != '0) mMask = mMask & condNz;
                else if (mStkMask.size() == 0) mUnf = 1;
                else begin
                  mMask = mStkMask.pop_back();
                  mRedirPc = mStkPc.pop_back();
                  mRedir = 1;
                end
          2'd3: mDone = 1;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk("R3 mask", actMask, mMask);
      chk("R4 redirect valid", redirValid, mRedir);
      if (mRedir) chk("R4 redirect pc", redirPc, mRedirPc);
      chk("R6 overflow", ovfErr, mOvf);
      chk("R7 underflow", unfErr, mUnf);
      chk("R9 done", waveDone, mDone);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic v, input logic [1:0] c, input logic [LANES-1:0] cond,
                      input logic [PCW-1:0] pc);
    opValid = v; opCode = c; condNz = cond; pushPc = pc;
    @(negedge clk);
    opValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset mask", actMask, 8'hFF);
    chk("R1 reset flags", {redirValid, ovfErr, unfErr, waveDone}, 0);

    step(0, 2'd2, 8'h00, 16'h0);
    chk("R10 idle no effect", actMask, 8'hFF);
    step(1, 2'd0, 8'h00, 16'h0);
    chk("R8 neutral no effect", actMask, 8'hFF);

    step(1, 2'd1, 8'h00, 16'h0040);
    chk("R2 push keeps mask", actMask, 8'hFF);
    step(1, 2'd2, 8'h0F, 16'h0);
    chk("R3 narrowed", actMask, 8'h0F);
    step(1, 2'd2, 8'hF0, 16'h0);
    chk("R4 pop restores", actMask, 8'hFF);
    chk("R2 saved label", redirPc, 16'h0040);
    step(1, 2'd0, 8'h00, 16'h0);
    chk("R4 one-cycle redirect", redirValid, 0);

    // loop: lanes drop out one per iteration
    step(1, 2'd1, 8'h00, 16'h0080);
    for (int i = 1; i <= 8; i++) begin
      step(1, 2'd2, 8'(8'hFF << i), 16'h0);
      step(1, 2'd0, 8'h00, 16'h0);
    end
    chk("R3 loop exit mask", actMask, 8'hFF);

    // nesting
    step(1, 2'd1, 8'h00, 16'h0010);
    step(1, 2'd2, 8'h33, 16'h0);
    step(1, 2'd1, 8'h00, 16'h0020);
    step(1, 2'd2, 8'h0F, 16'h0);
    chk("R3 inner mask", actMask, 8'h03);
    step(1, 2'd2, 8'h0C, 16'h0);
    chk("R5 inner pop mask", actMask, 8'h33);
    chk("R5 inner pop pc", redirPc, 16'h0020);
    step(1, 2'd2, 8'h00, 16'h0);
    chk("R5 outer pop mask", actMask, 8'hFF);
    chk("R5 outer pop pc", redirPc, 16'h0010);

    // underflow
    step(1, 2'd2, 8'h00, 16'h0);
    chk("R7 underflow set", unfErr, 1);
    chk("R7 no redirect", redirValid, 0);
    chk("R7 mask kept", actMask, 8'hFF);

    // overflow
    for (int i = 0; i < DEPTH + 1; i++) begin
      step(1, 2'd2, 8'(8'hFF >> i), 16'h0);
      step(1, 2'd1, 8'h00, 16'(16'h0100 + i));
    end
    chk("R6 overflow set", ovfErr, 1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      step(1, 2'd2, 8'h00, 16'h0);
      chk("R6 stack intact pc", redirPc, 16'h0100 + i);
    end
    chk("R6 bottom mask", actMask, 8'hFF);

    // return
    step(1, 2'd3, 8'h00, 16'h0);
    chk("R9 done set", waveDone, 1);
    step(1, 2'd2, 8'h01, 16'h0);
    chk("R9 narrow ignored", actMask, 8'hFF);
    step(1, 2'd1, 8'h00, 16'h0200);
    step(1, 2'd2, 8'h00, 16'h0);
    chk("R9 ops ignored", {redirValid, actMask}, {1'b0, 8'hFF});

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule